// File: doc/BRIEF.md
# Serial Clock-Configuration Register Slave

This block is the write-only configuration port of a clock generator. It listens on a two-wire bus, a serial clock line and an open-drain data line. A transfer opens with a start condition, followed by a 7-bit device address and a direction bit. When the address is the device's own and the direction is write, the block acknowledges. It then stores the bytes that follow in a small register file. The register file holds one function byte, with the test-mode and output-float controls, and several enable bytes that switch individual clock outputs on or off.

No register address is sent on the bus. The first data byte after the address always lands in register 0, the next one in register 1, and so on. A stop or a repeated start takes the pointer back to register 0. The register contents reach the output-control logic as parallel enable and mode signals. Both bus lines are brought into the system clock domain through a synchroniser chain before any edge is decoded.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: After reset, `test_mode_o` and `tristate_o` are 0, and every clock enable output is 1.
- R2: A start (data falling while the serial clock is high), then the address 1101001 sent as bits A6..A0, then a direction bit of 0, makes the block pull data low (`sda_oe_o`=1) during the ninth clock of that byte.
- R3: After any other address, the block never pulls data low, and the bytes that follow change no output until the next start.
- R4: The address 1101001 with a direction bit of 1 (read) is not acknowledged, and the bytes that follow change no output.
- R5: Data bytes arrive most significant bit first. The first data byte goes to register 0, in which bit 0 drives `test_mode_o` and bit 1 drives `tristate_o`.
- R6: In register 1, bits 3..0 drive `cpu_en_o[3:0]` and bit 7 drives `usb_en_o`. In register 2, bits 5..0 drive `pci_en_o[5:0]` and bit 6 drives `pcif_en_o`.
- R7: Register 3 drives `sdram_en_o[7:0]`, and bits 3..0 of register 4 drive `sdram_en_o[11:8]`. In register 5, bit 0 drives `ref_en_o` and bit 4 drives `ioapic_en_o`.
- R8: Every data byte of an accepted transfer is acknowledged. Register 6 and any byte beyond it are acknowledged but change no output.
- R9: A stop or a repeated start takes the register pointer back to register 0.
- R10: A byte cut short by a stop before its eighth bit is not stored.
- R11: Bits that have no function (register 0 bits 7..2, register 1 bits 6..4, register 2 bit 7, register 4 bits 7..4, register 5 bits 7..5 and 3..1) have no effect on any output, whatever value is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line (bus level) |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| test_mode_o | output | 1 | Test mode select |
| tristate_o | output | 1 | Float all clock outputs |
| cpu_en_o | output | 4 | Processor clock enables |
| usb_en_o | output | 1 | 48 MHz clock enable |
| pci_en_o | output | 6 | Stoppable peripheral-bus clock enables |
| pcif_en_o | output | 1 | Free-running peripheral-bus clock enable |
| sdram_en_o | output | 12 | Memory clock enables |
| ref_en_o | output | 1 | Reference clock enable |
| ioapic_en_o | output | 1 | Interrupt-controller clock enable |

## Verification
The bench builds the block with its default values: a two-stage synchroniser and the device address 1101001. The bus model holds each serial-clock phase for five system clocks. That leaves margin over the three cycles the synchroniser and edge decode take, while the acknowledge is still asserted and released inside the clock-low phase. Because each transfer is short, the random loop fits in many of them. These transfers mix foreign and read addresses, lengths of zero to nine bytes, and over-length writes past the reserved register.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

   // register file geometry
   localparam int CFG_BYTES = 7;
   localparam int IDX_W     = $clog2(CFG_BYTES + 1);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_DATA,
      ST_ACK,
      ST_SKIP
   } link_st_t;

   // bits that carry a function in each register
   function automatic logic [7:0] impl_mask(input int idx);
      case (idx)
         0:       return 8'h03;
         1:       return 8'h8F;
         2:       return 8'h7F;
         3:       return 8'hFF;
         4:       return 8'h0F;
         5:       return 8'h11;
         default: return 8'h00;
      endcase
   endfunction

   // function byte clears, enable bytes come up active
   function automatic logic [7:0] reset_val(input int idx);
      return (idx == 0) ? 8'h00 : impl_mask(idx);
   endfunction

endpackage

// File: rtl/clkcfg_sync.sv
module clkcfg_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkcfg_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("clkcfg_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] pipe [STAGES];

   // idle bus level is high, so flops reset to ones
   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= '1;
               else        pipe[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= '1;
               else        pipe[s] <= pipe[s-1];
            end
         end
      end
   endgenerate

   assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/clkcfg_link.sv
module clkcfg_link
   import clkcfg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1101001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_s,
   input  logic             sda_s,
   output logic             sda_oe_o,
   output logic             wr_en_o,
   output logic [IDX_W-1:0] wr_idx_o,
   output logic [7:0]       wr_data_o
);

   localparam logic [7:0]       WR_MATCH = {DEV_ADDR, 1'b0};
   localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(CFG_BYTES);

   link_st_t         st;
   logic             scl_q, sda_q;
   logic [3:0]       bit_cnt;
   logic [7:0]       shreg;
   logic [IDX_W-1:0] byte_idx;

   // line events, decoded on the synchronised levels
   logic scl_rise, scl_fall, start_det, stop_det;
   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         bit_cnt   <= '0;
         shreg     <= '0;
         byte_idx  <= '0;
         sda_oe_o  <= 1'b0;
         wr_en_o   <= 1'b0;
         wr_idx_o  <= '0;
         wr_data_o <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (start_det) begin
            st       <= ST_ADDR;
            bit_cnt  <= '0;
            byte_idx <= '0;
            sda_oe_o <= 1'b0;
         end else if (stop_det) begin
            st       <= ST_IDLE;
            bit_cnt  <= '0;
            byte_idx <= '0;
            sda_oe_o <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_DATA: begin
                  if (scl_rise && bit_cnt < 4'd8) begin
                     shreg   <= {shreg[6:0], sda_s};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     if (st == ST_ADDR) begin
                        if (shreg == WR_MATCH) begin
                           sda_oe_o <= 1'b1;
                           st       <= ST_ACK;
                        end else begin
                           st <= ST_SKIP;
                        end
                     end else begin
                        sda_oe_o <= 1'b1;
                        st       <= ST_ACK;
                        if (byte_idx != IDX_END) begin
                           wr_en_o   <= 1'b1;
                           wr_idx_o  <= byte_idx;
                           wr_data_o <= shreg;
                           byte_idx  <= byte_idx + 1'b1;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     sda_oe_o <= 1'b0;
                     bit_cnt  <= '0;
                     st       <= ST_DATA;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // acknowledge only begins while the clock line is low (R2)
   assert_ack_low_scl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !scl_s);

   // an ignored transfer never drives the line (R3)
   assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SKIP) |-> !sda_oe_o);

   // stop returns the pointer to register 0 and releases the line (R9)
   assert_stop_rewind_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (byte_idx == '0 && !sda_oe_o && st == ST_IDLE));

   // repeated start re-enters the address phase at register 0 (R9)
   assert_start_rewind_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (st == ST_ADDR && byte_idx == '0));

   // bit counter never runs past the acknowledge slot (R5)
   assert_bitcnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= 4'd8);

endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
   import clkcfg_pkg::*;
(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en_i,
   input  logic [IDX_W-1:0]            wr_idx_i,
   input  logic [7:0]                  wr_data_i,
   output logic [CFG_BYTES-1:0][7:0]   cfg_o
);

   generate
      for (genvar i = 0; i < CFG_BYTES; i++) begin : g_byte
         localparam logic [7:0] MASK = impl_mask(i);
         localparam logic [7:0] RVAL = reset_val(i);
         if (MASK == 8'h00) begin : g_none
            assign cfg_o[i] = 8'h00;
         end else begin : g_store
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q <= RVAL;
               else if (wr_en_i && wr_idx_i == IDX_W'(i))
                  q <= wr_data_i & MASK;
            end
            assign cfg_o[i] = q;
         end
      end
   endgenerate

   // writes never address past the last register (R8)
   assert_wr_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |-> (wr_idx_i < IDX_W'(CFG_BYTES)));

   // contents move only on a write strobe (R10)
   assert_hold_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(cfg_o));

endmodule

// File: rtl/clkcfg_serial_slave.sv
module clkcfg_serial_slave
   import clkcfg_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] DEV_ADDR    = 7'b1101001
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_i,
   input  logic        sda_i,
   output logic        sda_oe_o,
   output logic        test_mode_o,
   output logic        tristate_o,
   output logic [3:0]  cpu_en_o,
   output logic        usb_en_o,
   output logic [5:0]  pci_en_o,
   output logic        pcif_en_o,
   output logic [11:0] sdram_en_o,
   output logic        ref_en_o,
   output logic        ioapic_en_o
);

   generate
      if (CFG_BYTES < 6) begin : g_bad_map
         $error("clkcfg_serial_slave: register map needs at least 6 bytes");
      end
   endgenerate

   logic [1:0]               line_s;
   logic                     wr_en;
   logic [IDX_W-1:0]         wr_idx;
   logic [7:0]               wr_data;
   logic [CFG_BYTES-1:0][7:0] cfg;

   clkcfg_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   (line_s)
   );

   clkcfg_link #(.DEV_ADDR(DEV_ADDR)) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (line_s[1]),
      .sda_s     (line_s[0]),
      .sda_oe_o  (sda_oe_o),
      .wr_en_o   (wr_en),
      .wr_idx_o  (wr_idx),
      .wr_data_o (wr_data)
   );

   clkcfg_regfile u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_idx_i  (wr_idx),
      .wr_data_i (wr_data),
      .cfg_o     (cfg)
   );

   assign test_mode_o = cfg[0][0];
   assign tristate_o  = cfg[0][1];
   assign cpu_en_o    = cfg[1][3:0];
   assign usb_en_o    = cfg[1][7];
   assign pci_en_o    = cfg[2][5:0];
   assign pcif_en_o   = cfg[2][6];
   assign sdram_en_o  = {cfg[4][3:0], cfg[3]};
   assign ref_en_o    = cfg[5][0];
   assign ioapic_en_o = cfg[5][4];

endmodule

// File: tb/clkcfg_serial_slave_tb.sv
module clkcfg_serial_slave_tb;

   localparam int Q = 5;
   localparam logic [6:0] MY_ADDR = 7'b1101001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_bus;
   assign sda_bus = sda_m & ~sda_oe;

   logic        test_mode, tristate, usb_en, pcif_en, ref_en, ioapic_en;
   logic [3:0]  cpu_en;
   logic [5:0]  pci_en;
   logic [11:0] sdram_en;

   clkcfg_serial_slave u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_m),
      .sda_i       (sda_bus),
      .sda_oe_o    (sda_oe),
      .test_mode_o (test_mode),
      .tristate_o  (tristate),
      .cpu_en_o    (cpu_en),
      .usb_en_o    (usb_en),
      .pci_en_o    (pci_en),
      .pcif_en_o   (pcif_en),
      .sdram_en_o  (sdram_en),
      .ref_en_o    (ref_en),
      .ioapic_en_o (ioapic_en)
   );

   int errs = 0;
   int checks = 0;
   logic [7:0] exp_b [7];
   logic [7:0] dbuf [12];

   function automatic logic [7:0] fmask(input int i);
      case (i)
         0: return 8'b0000_0011;
         1: return 8'b1000_1111;
         2: return 8'b0111_1111;
         3: return 8'b1111_1111;
         4: return 8'b0000_1111;
         5: return 8'b0001_0001;
         default: return 8'b0;
      endcase
   endfunction

   function automatic logic [7:0] observed(input int i);
      case (i)
         0: return {6'b0, tristate, test_mode};
         1: return {usb_en, 3'b0, cpu_en};
         2: return {1'b0, pcif_en, pci_en};
         3: return sdram_en[7:0];
         4: return {4'b0, sdram_en[11:8]};
         5: return {3'b0, ioapic_en, 3'b0, ref_en};
         default: return 8'b0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_regs(input string tag);
      for (int i = 0; i < 6; i++) chk(tag, 32'(observed(i)), 32'(exp_b[i] & fmask(i)));
   endtask

   task automatic half();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; half();
      scl_m = 1'b1; half();
      sda_m = 1'b0; half();
      scl_m = 1'b0; half();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; half();
      scl_m = 1'b1; half();
      sda_m = 1'b1; half(); half();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b;    half();
      scl_m = 1'b1; half(); half();
      scl_m = 1'b0; half();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; half();
      scl_m = 1'b1; half();
      ack = sda_bus;
      half();
      scl_m = 1'b0; half();
   endtask

   // one transfer; ack expected low only for own address with write
   task automatic xfer(input logic [6:0] addr, input logic rw, input int n,
                       input string tag, input logic keep_open);
      logic a;
      logic ok;
      ok = (addr == MY_ADDR) && !rw;
      bus_start();
      send_byte({addr, rw}, a);
      chk(tag, 32'(a), 32'(!ok));
      for (int k = 0; k < n; k++) begin
         send_byte(dbuf[k], a);
         chk(tag, 32'(a), 32'(!ok));
         if (ok && k < 7) exp_b[k] = dbuf[k];
      end
      if (!keep_open) bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic a;
      void'($urandom(32'h0C1F_2273));
      for (int i = 0; i < 7; i++) exp_b[i] = (i == 0) ? 8'h00 : 8'hFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset state
      check_regs("R1 reset");
      chk("R1 sda_oe idle", 32'(sda_oe), 32'd0);

      // R2 R5 R6 R7 full write with asymmetric values
      dbuf[0] = 8'h01; dbuf[1] = 8'h81; dbuf[2] = 8'h45; dbuf[3] = 8'h3C;
      dbuf[4] = 8'h09; dbuf[5] = 8'h10; dbuf[6] = 8'hAA;
      xfer(MY_ADDR, 1'b0, 7, "R2 R5 R6 R7 write", 1'b0);
      check_regs("R5 R6 R7 mapping");

      // R11 reserved bits written as ones
      dbuf[0] = 8'hFE; dbuf[1] = 8'h70; dbuf[2] = 8'h80; dbuf[3] = 8'h00;
      dbuf[4] = 8'hF0; dbuf[5] = 8'hEE;
      xfer(MY_ADDR, 1'b0, 6, "R11 write", 1'b0);
      check_regs("R11 reserved");

      // R3 foreign address
      for (int k = 0; k < 6; k++) dbuf[k] = 8'hFF;
      xfer(7'b1101000, 1'b0, 6, "R3 foreign ack", 1'b0);
      check_regs("R3 foreign ignored");

      // R4 read request
      xfer(MY_ADDR, 1'b1, 6, "R4 read ack", 1'b0);
      check_regs("R4 read ignored");

      // R8 over-length write: bytes 6..8 acked, no effect
      dbuf[0] = 8'h02; dbuf[1] = 8'h0F; dbuf[2] = 8'h3F; dbuf[3] = 8'h55;
      dbuf[4] = 8'h0A; dbuf[5] = 8'h01; dbuf[6] = 8'hFF; dbuf[7] = 8'h00; dbuf[8] = 8'h00;
      xfer(MY_ADDR, 1'b0, 9, "R8 over-length ack", 1'b0);
      check_regs("R8 extra discarded");

      // R9 repeated start returns to register 0
      dbuf[0] = 8'h00; dbuf[1] = 8'h8E;
      xfer(MY_ADDR, 1'b0, 2, "R9 first part", 1'b1);
      dbuf[0] = 8'h03;
      xfer(MY_ADDR, 1'b0, 1, "R9 after restart", 1'b0);
      check_regs("R9 restart to byte 0");

      // R10 partial byte then stop
      bus_start();
      send_byte({MY_ADDR, 1'b0}, a);
      chk("R10 addr ack", 32'(a), 32'd0);
      send_byte(8'h00, a);
      chk("R10 byte ack", 32'(a), 32'd0);
      exp_b[0] = 8'h00;
      send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
      bus_stop();
      check_regs("R10 partial not stored");

      // R9 stop then new transfer starts at byte 0
      dbuf[0] = 8'h02;
      xfer(MY_ADDR, 1'b0, 1, "R9 after stop", 1'b0);
      check_regs("R9 stop to byte 0");

      // random mix
      for (int t = 0; t < 30; t++) begin
         logic [6:0] ad;
         logic rw;
         int n;
         ad = ($urandom % 6 == 0) ? 7'($urandom) : MY_ADDR;
         rw = ($urandom % 6 == 0);
         n  = $urandom % 10;
         for (int k = 0; k < 12; k++) dbuf[k] = 8'($urandom);
         xfer(ad, rw, n, "R3 R4 R8 random", 1'b0);
         check_regs("R6 R7 random");
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule